// File: doc/BRIEF.md
# Accumulator ALU with Registered Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor. On every cycle it combines a register operand and a memory operand under a 4-bit operation code and presents an 8-bit result on its output with no clock delay. A write-enable output says whether the operation produces a value that should be written back.

The processor's decode logic supplies the current flag byte. When the update strobe is high, the block computes the new flag byte from that input and the operation, and registers it. Decimal mode is only a stored bit: arithmetic is always binary.

Operation codes on `op_i`: 0 add with carry, 1 subtract with borrow, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 logical shift right, 7 rotate left, 8 rotate right, 9 increment, 10 decrement, 11 compare, 12 bit test, 13 clear overflow, 14 and 15 reserved.

Flag byte bit positions, from bit 7 down to bit 0: N (negative), V (overflow), always-one, B (break), D (decimal), I (interrupt disable), Z (zero), C (carry).

Top module: `acc_alu`

## Requirements
- R1: After reset `flags_o` is 8'h24. Bit 5 of `flags_o` reads 1 at all times.
- R2: While `valid_i` is low, `flags_o` keeps its value across clock edges.
- R3: Add (code 0) gives result = reg + mem + C, taken modulo 256. The new C is the carry out of bit 7. V is set when both operands have the same sign bit and the result's sign bit differs from it. N equals result bit 7, and Z is set when the result is zero.
- R4: Subtract (code 1) gives result = reg - mem - (1 - C), taken modulo 256. The new C is 1 when no borrow occurred. V is set on signed overflow of the subtraction. N and Z follow the result.
- R5: AND, OR and XOR (codes 2, 3, 4) combine reg and mem bit by bit. They update only N and Z; V and C keep their input values.
- R6: Shift left (code 5) moves mem bit 7 into C and inserts 0 at bit 0. Logical shift right (code 6) moves mem bit 0 into C and inserts 0 at bit 7. N and Z follow the result, and V is unchanged.
- R7: Rotate left (code 7) inserts the incoming C at bit 0 of mem and moves bit 7 into C. Rotate right (code 8) inserts the incoming C at bit 7 and moves bit 0 into C. N and Z follow the result, and V is unchanged.
- R8: Increment (code 9) and decrement (code 10) act on mem and wrap modulo 256. They change only N and Z; C and V are unchanged.
- R9: Compare (code 11) sets C when reg >= mem (unsigned). It sets Z when reg == mem and N to bit 7 of (reg - mem) mod 256. V is unchanged and `wr_o` is low.
- R10: Bit test (code 12) copies mem bit 7 to N and mem bit 6 to V. It sets Z when (reg AND mem) is zero. C is unchanged and `wr_o` is low.
- R11: Clear overflow (code 13) clears only V. Reserved codes 14 and 15 leave the flags equal to the input flags with bit 5 set. For codes 11 to 15, `result_o` equals reg.
- R12: B, D and I are copied from `flags_i` by every operation. A set D does not change any arithmetic result.
- R13: `wr_o` is high for codes 0 to 10 and low for codes 11 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Update strobe: register the new flags this cycle |
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register operand |
| mem_i | input | 8 | Memory operand; also the target of shifts, increment and decrement |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 8 | Combinational result |
| wr_o | output | 1 | Result is meant to be written back |
| flags_o | output | 8 | Registered flag byte |

## Verification
The assertions assume that `op_i`, the operands and `flags_i` are known and stable around each rising edge while `valid_i` is high. They also assume that `valid_i` is never unknown once reset is released. The stimulus meets this by changing every input only at the falling edge and holding `valid_i` at a defined level from time zero.

The bench drives `flags_i` directly rather than feeding `flags_o` back. This lets each operation see every combination of incoming carry, overflow and control bits.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int FLAG_W = 8;
    localparam int FL_C   = 0;
    localparam int FL_Z   = 1;
    localparam int FL_I   = 2;
    localparam int FL_D   = 3;
    localparam int FL_B   = 4;
    localparam int FL_ONE = 5;
    localparam int FL_V   = 6;
    localparam int FL_N   = 7;

    localparam logic [FLAG_W-1:0] FLAGS_RST = 8'h24;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_CMP  = 4'd11,
        OP_BIT  = 4'd12,
        OP_CLRV = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } alu_state_t;

endpackage

// File: rtl/acc_alu_add.sv
module acc_alu_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] d_i,
    input  logic         cin_i,
    input  logic [1:0]   mode_i,
    output logic [W-1:0] d_o,
    output logic         cout_o
);
    logic fill;

    always_comb begin
        fill = mode_i[1] ? cin_i : 1'b0;
        if (mode_i[0]) begin
            d_o    = {fill, d_i[W-1:1]};
            cout_o = d_i[0];
        end else begin
            d_o    = {d_i[W-2:0], fill};
            cout_o = d_i[W-1];
        end
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] y_o
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        always_comb begin
            case (sel_i)
                2'd0:    y_o[k] = a_i[k] & b_i[k];
                2'd1:    y_o[k] = a_i[k] | b_i[k];
                default: y_o[k] = a_i[k] ^ b_i[k];
            endcase
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DW-1:0]     reg_i,
    input  logic [DW-1:0]     mem_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DW-1:0]     result_o,
    output logic              wr_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int MSB = DW - 1;

    alu_op_e    op;
    alu_state_t st_d, st_q;

    logic [DW-1:0] add_sum, shf_out, log_out, step_out;
    logic          add_c, add_v, shf_c, add_sub, add_cin;
    logic [1:0]    shf_mode, log_sel;

    assign op = alu_op_e'(op_i);

    always_comb begin
        add_sub  = (op == OP_SUB) || (op == OP_CMP);
        add_cin  = (op == OP_CMP) ? 1'b1 : flags_i[FL_C];
        shf_mode = 2'(op_i - 4'd5);
        log_sel  = 2'(op_i - 4'd2);
        step_out = (op == OP_INC) ? mem_i + 1'b1 : mem_i - 1'b1;
    end

    acc_alu_add #(.W(DW)) u_add (
        .a_i(reg_i), .b_i(mem_i), .cin_i(add_cin), .sub_i(add_sub),
        .sum_o(add_sum), .cout_o(add_c), .ovf_o(add_v)
    );

    acc_alu_shift #(.W(DW)) u_shf (
        .d_i(mem_i), .cin_i(flags_i[FL_C]), .mode_i(shf_mode),
        .d_o(shf_out), .cout_o(shf_c)
    );

    acc_alu_logic #(.W(DW)) u_log (
        .a_i(reg_i), .b_i(mem_i), .sel_i(log_sel), .y_o(log_out)
    );

    // result and write-back select
    always_comb begin
        result_o = reg_i;
        wr_o     = 1'b1;
        case (op)
            OP_ADD, OP_SUB:                 result_o = add_sum;
            OP_AND, OP_OR, OP_XOR:          result_o = log_out;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: result_o = shf_out;
            OP_INC, OP_DEC:                 result_o = step_out;
            default:                        wr_o     = 1'b0;
        endcase
    end

    // next flag state
    always_comb begin
        logic [FLAG_W-1:0] f;
        st_d = st_q;
        f    = flags_i;
        case (op)
            OP_ADD, OP_SUB: begin
                f[FL_C] = add_c;
                f[FL_V] = add_v;
                f[FL_N] = add_sum[MSB];
                f[FL_Z] = (add_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC: begin
                f[FL_N] = result_o[MSB];
                f[FL_Z] = (result_o == '0);
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                f[FL_C] = shf_c;
                f[FL_N] = shf_out[MSB];
                f[FL_Z] = (shf_out == '0);
            end
            OP_CMP: begin
                f[FL_C] = add_c;
                f[FL_N] = add_sum[MSB];
                f[FL_Z] = (add_sum == '0);
            end
            OP_BIT: begin
                f[FL_N] = mem_i[MSB];
                f[FL_V] = mem_i[MSB-1];
                f[FL_Z] = ((reg_i & mem_i) == '0);
            end
            OP_CLRV: f[FL_V] = 1'b0;
            default: ;
        endcase
        f[FL_ONE] = 1'b1;
        if (valid_i) st_d.flags = f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flags: FLAGS_RST};
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_i,
    input logic [3:0] op_i,
    input logic [7:0] reg_i,
    input logic [7:0] mem_i,
    input logic [7:0] flags_i,
    input logic       wr_o,
    input logic [7:0] flags_o
);
    AST_UNUSED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[5]); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(flags_o)); // R2
    AST_LOGIC_KEEP_VC: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (op_i >= 4'd2) && (op_i <= 4'd4)
        |=> flags_o[6] == $past(flags_i[6]) && flags_o[0] == $past(flags_i[0])); // R5
    AST_STEP_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (op_i == 4'd9 || op_i == 4'd10)
        |=> flags_o[0] == $past(flags_i[0])); // R8
    AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i == 4'd11 |=> flags_o[0] == ($past(reg_i) >= $past(mem_i))); // R9
    AST_BIT_NV: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && op_i == 4'd12 |=> flags_o[7:6] == $past(mem_i[7:6])); // R10
    AST_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> flags_o[4:2] == $past(flags_i[4:2])); // R12
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_i >= 4'd11 |-> !wr_o); // R13
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .reg_i(reg_i), .mem_i(mem_i), .flags_i(flags_i),
    .wr_o(wr_o), .flags_o(flags_o)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] reg_i = 8'd0, mem_i = 8'd0, flags_i = 8'd0;
    logic [7:0] result_o, flags_o;
    logic       wr_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;   // 50 MHz

    acc_alu u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .reg_i(reg_i), .mem_i(mem_i), .flags_i(flags_i),
        .result_o(result_o), .wr_o(wr_o), .flags_o(flags_o)
    );

    function automatic string req_of(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2, 3, 4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            9, 10: return "R8";
            11: return "R9";
            12: return "R10";
            default: return "R11";
        endcase
    endfunction

    // independent model: {we, result, flags}
    function automatic logic [16:0] model(int op, logic [7:0] a, logic [7:0] m, logic [7:0] f);
        int s;
        logic [7:0] r = a;
        logic [7:0] nf = f;
        logic we = 1'b0;
        logic nz = 1'b0;
        logic c = f[0];
        case (op)
            0: begin s = int'(a) + int'(m) + int'(c); r = s[7:0]; nf[0] = s > 255;
                     nf[6] = ((a ^ r) & (m ^ r)) >= 8'h80; we = 1; nz = 1; end
            1: begin s = int'(a) - int'(m) - (1 - int'(c)); r = s[7:0]; nf[0] = s >= 0;
                     nf[6] = ((a ^ m) & (a ^ r)) >= 8'h80; we = 1; nz = 1; end
            2: begin r = a & m; we = 1; nz = 1; end
            3: begin r = a | m; we = 1; nz = 1; end
            4: begin r = a ^ m; we = 1; nz = 1; end
            5: begin r = m << 1; nf[0] = m[7]; we = 1; nz = 1; end
            6: begin r = m >> 1; nf[0] = m[0]; we = 1; nz = 1; end
            7: begin r = {m[6:0], c}; nf[0] = m[7]; we = 1; nz = 1; end
            8: begin r = {c, m[7:1]}; nf[0] = m[0]; we = 1; nz = 1; end
            9: begin r = 8'((int'(m) + 1) % 256); we = 1; nz = 1; end
            10: begin r = 8'((int'(m) + 255) % 256); we = 1; nz = 1; end
            11: begin nf[0] = a >= m; nf[1] = a == m; s = int'(a) - int'(m); nf[7] = s[7]; end
            12: begin nf[7] = m[7]; nf[6] = m[6]; nf[1] = (a & m) == 0; end
            13: nf[6] = 1'b0;
            default: ;
        endcase
        if (nz) begin nf[7] = r[7]; nf[1] = (r == 0); end
        nf[5] = 1'b1;
        return {we, r, nf};
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(int op, logic [7:0] a, logic [7:0] m, logic [7:0] f);
        logic [16:0] e;
        e = model(op, a, m, f);
        @(negedge clk);
        valid_i = 1'b1; op_i = 4'(op); reg_i = a; mem_i = m; flags_i = f;
        #2;
        check8(req_of(op), "result", result_o, e[15:8]);
        check8("R13", "wr", {7'd0, wr_o}, {7'd0, e[16]});
        @(posedge clk); #2;
        check8(req_of(op), "flags", flags_o, e[7:0]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check8("R1", "reset flags", flags_o, 8'h24);
        rst_n = 1'b1;
    endtask

    task automatic t_hold();
        logic [7:0] keep;
        run_op(0, 8'h7F, 8'h01, 8'h00);   // leaves N,V set
        keep = flags_o;
        @(negedge clk);
        valid_i = 1'b0; op_i = 4'd13; flags_i = 8'h00; reg_i = 8'h00; mem_i = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        check8("R2", "idle hold", flags_o, keep);
    endtask

    task automatic t_corners();
        run_op(0, 8'h80, 8'h80, 8'h00);   // R3: carry and overflow, zero result
        run_op(0, 8'hFF, 8'h00, 8'h01);   // R3: carry-in ripples
        run_op(1, 8'h00, 8'h01, 8'h01);   // R4: borrow clears C
        run_op(1, 8'h80, 8'h01, 8'h01);   // R4: signed overflow
        run_op(1, 8'h05, 8'h05, 8'h00);   // R4: borrow-in only
        run_op(2, 8'hF0, 8'h0F, 8'h41);   // R5: V and C kept
        run_op(5, 8'h00, 8'h80, 8'h40);   // R6: V kept, C set, zero
        run_op(6, 8'h00, 8'h01, 8'h00);   // R6
        run_op(7, 8'h00, 8'h80, 8'h01);   // R7
        run_op(8, 8'h00, 8'h01, 8'h01);   // R7
        run_op(9, 8'h00, 8'hFF, 8'h41);   // R8: wrap up, C and V kept
        run_op(10, 8'h00, 8'h00, 8'h00);  // R8: wrap down
        run_op(11, 8'h42, 8'h42, 8'h40);  // R9: equal
        run_op(11, 8'h01, 8'hFF, 8'h01);  // R9: less
        run_op(12, 8'h0F, 8'hC0, 8'h00);  // R10
        run_op(13, 8'h00, 8'h00, 8'hFF);  // R11
        run_op(14, 8'h12, 8'h34, 8'hC3);  // R11 reserved
        run_op(0, 8'h09, 8'h01, 8'h08);   // R12: decimal set, stays binary
    endtask

    task automatic t_sweep();
        logic [7:0] mset [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h55};
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int mi = 0; mi < 8; mi++)
                    for (int c = 0; c < 2; c++) begin
                        logic [7:0] av = 8'(a);
                        logic [7:0] f = {mset[mi][7] ^ av[0], av[1], 1'b0, av[2], av[3], av[4], av[5], 1'(c)};
                        run_op(op, av, mset[mi], f);
                    end
    endtask

    initial begin
        t_reset();
        t_hold();
        t_corners();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule